// File: doc/BRIEF.md
# Switch Table Indirect Access Controller

This block lets a processor reach the internal tables of a small Ethernet switch without mapping them into its address space. Four tables sit behind one narrow register window: a VLAN table, a static MAC table, a dynamic (learned) MAC table and a bank of MIB counters. Each table entry is up to 69 bits wide and is carried in three data registers: a low word, a middle word and a five-bit high word.

To write an entry, the processor loads the data registers and then writes a command word with the direction bit clear. The entry is stored on that same clock edge. To read an entry, it writes a command word with the direction bit set. The controller then goes busy for a fixed number of cycles, because the tables sit behind a slow fetch path. While it is busy, the data registers show a placeholder, and for the dynamic table that placeholder carries a not-ready flag. When busy drops, the data registers hold the fetched entry. Learning and forwarding are outside this block: the tables here are plain storage.

Top module: `sw_tbl_access`

## Requirements
- R1: A write to register address 3 issues a command. Bit 12 is the direction (1 read, 0 write), bits 11:10 select the table (0 static MAC, 1 VLAN, 2 dynamic MAC, 3 MIB) and bits 9:0 give the index. A write command completes on its own edge and does not raise busy_o.
- R2: Register addresses 0, 1 and 2 load the low data word (entry bits 31:0), the middle word (entry bits 63:32) and the high word (entry bits 68:64, taken from write bits 4:0). The data registers are always visible on data_lo_o, data_mid_o and data_hi_o.
- R3: After a read command, busy_o is high for exactly READ_LAT cycles (default 3). On the edge where busy_o falls, the data registers take the fetched entry.
- R4: While a read is pending, the data registers read zero. For a dynamic-table read, entry bit 55 (middle word bit 23, not-ready) is set in that placeholder. It is clear in the fetched dynamic entry.
- R5: The VLAN table has 16 entries of 22 bits (valid 21, member ports 20:16, filter ID 15:12, VLAN ID 11:0). A read returns the stored bits with all higher bits zero.
- R6: The static MAC table has 8 entries of 60 bits (MAC 47:0, port mask 52:48, valid 53, override 54, use-filter-ID 55, filter ID 59:56). A write with bit 53 clear stores an all-zero entry.
- R7: The dynamic table has 1024 entries storing MAC 47:0, filter ID 51:48, source port 54:52 and age 57:56. A read adds, in bits 67:58, the number of distinct indices written so far, minus one, and in bit 68 a flag that is set while no index has been written. An index never written reads zero in its entry fields.
- R8: The MIB bank has 32 counters of 32 bits, held in the low word. A read returns the counter and clears it.
- R9: A read of an index at or beyond a table's size returns all zero, and a write to such an index changes no entry.
- R10: While busy_o is high, register writes and commands are ignored.
- R11: After reset, the data registers are zero, busy_o is low and every table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 low, 1 middle, 2 high, 3 command |
| reg_wdata_i | input | 32 | Register write data |
| data_lo_o | output | 32 | Data register, entry bits 31:0 |
| data_mid_o | output | 32 | Data register, entry bits 63:32 |
| data_hi_o | output | 5 | Data register, entry bits 68:64 |
| busy_o | output | 1 | Read in progress |

## Verification
The bench goes after index aliasing by writing past the end of the VLAN, static and MIB tables. A design that dropped the range check would then corrupt the entry at the index modulo the table size. It rewrites a dynamic index to catch a count that grows on every write instead of on each new index, and it reads an empty dynamic table, where a missing empty flag shows up as an all-zero header. It writes a static entry with the valid bit clear over a live entry, which a design that stored the raw bits would leave readable. It reads a MIB counter twice to catch a missing clear-on-read, and it fires register writes and a command into a pending read, which a design without the busy guard would let through, corrupting both the result and the table.

// File: rtl/sw_tbl_pkg.sv
package sw_tbl_pkg;
  localparam int IDX_W    = 10;
  localparam int CMD_W    = 13;
  localparam int HI_W     = 5;
  localparam int ENTRY_W  = 64 + HI_W;
  localparam int VLAN_W   = 22;
  localparam int STAT_W   = 60;
  localparam int STAT_VLD = 53;
  localparam int DYN_W    = 57;
  localparam int NRDY_BIT = 55;

  typedef enum logic [1:0] {
    TBL_STATIC = 2'd0,
    TBL_VLAN   = 2'd1,
    TBL_DYN    = 2'd2,
    TBL_MIB    = 2'd3
  } tbl_sel_e;

  typedef enum logic [1:0] {
    REG_LO  = 2'd0,
    REG_MID = 2'd1,
    REG_HI  = 2'd2,
    REG_CMD = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             rd;
    tbl_sel_e         sel;
    logic [IDX_W-1:0] idx;
  } cmd_t;
endpackage

// File: rtl/sw_tbl_small_mem.sv
module sw_tbl_small_mem import sw_tbl_pkg::*; #(
  parameter int DEPTH     = 16,
  parameter int WIDTH     = 22,
  parameter bit CLR_ON_RD = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             rd_clr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic             in_range;
  logic [AW-1:0]    slot;

  assign in_range = ({1'b0, idx_i} < DEPTH_L);
  assign slot     = idx_i[AW-1:0];
  assign rdata_o  = in_range ? mem_q[slot] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && in_range) begin
      mem_q[slot] <= wdata_i;
    end else if (CLR_ON_RD && rd_clr_i && in_range) begin
      mem_q[slot] <= '0;
    end
  end
endmodule

// File: rtl/sw_tbl_dyn_mem.sv
module sw_tbl_dyn_mem import sw_tbl_pkg::*; #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = DYN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             in_range_o,
  output logic             empty_o,
  output logic [IDX_W-1:0] cnt_m1_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic             empty_q;
  logic [IDX_W-1:0] cnt_m1_q;
  logic [AW-1:0]    slot;
  logic             fresh;

  assign in_range_o = ({1'b0, idx_i} < DEPTH_L);
  assign slot       = idx_i[AW-1:0];
  assign fresh      = we_i && in_range_o && !vld_q[slot];
  assign rdata_o    = (in_range_o && vld_q[slot]) ? mem_q[slot] : '0;
  assign empty_o    = empty_q;
  assign cnt_m1_o   = cnt_m1_q;

  // storage needs no reset: the valid vector masks it
  always_ff @(posedge clk_i) begin
    if (we_i && in_range_o) mem_q[slot] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      empty_q  <= 1'b1;
      cnt_m1_q <= '0;
    end else if (fresh) begin
      vld_q[slot] <= 1'b1;
      if (empty_q) empty_q  <= 1'b0;
      else         cnt_m1_q <= cnt_m1_q + 1'b1;
    end
  end
endmodule

// File: rtl/sw_tbl_rd_seq.sv
module sw_tbl_rd_seq #(
  parameter int READ_LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(READ_LAT + 1);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(READ_LAT);
    else if (busy_o)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sw_tbl_access.sv
module sw_tbl_access import sw_tbl_pkg::*; #(
  parameter int VLAN_DEPTH = 16,
  parameter int STAT_DEPTH = 8,
  parameter int DYN_DEPTH  = 1024,
  parameter int MIB_DEPTH  = 32,
  parameter int READ_LAT   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     data_lo_o,
  output logic [31:0]     data_mid_o,
  output logic [HI_W-1:0] data_hi_o,
  output logic            busy_o
);
  localparam logic [31:0] NRDY_MASK = 32'(1) << (NRDY_BIT - 32);

  logic [31:0]      lo_q, mid_q;
  logic [HI_W-1:0]  hi_q;
  cmd_t             cmd_in, pend_q;
  logic             busy, done, accept, cmd_go, rd_go, wr_go;
  logic [IDX_W-1:0] mem_idx;
  logic [STAT_W-1:0] wr_entry;
  logic [ENTRY_W-1:0] rd_entry;

  logic [VLAN_W-1:0] vlan_rdata;
  logic [STAT_W-1:0] stat_rdata, stat_wdata;
  logic [DYN_W-1:0]  dyn_rdata;
  logic [31:0]       mib_rdata;
  logic              dyn_in_range, dyn_empty;
  logic [IDX_W-1:0]  dyn_cnt_m1;

  assign cmd_in   = cmd_t'(reg_wdata_i[CMD_W-1:0]);
  assign accept   = reg_we_i && !busy;
  assign cmd_go   = accept && (reg_sel_e'(reg_addr_i) == REG_CMD);
  assign rd_go    = cmd_go && cmd_in.rd;
  assign wr_go    = cmd_go && !cmd_in.rd;
  assign mem_idx  = busy ? pend_q.idx : cmd_in.idx;
  assign wr_entry = {mid_q[STAT_W-33:0], lo_q};
  assign stat_wdata = wr_entry[STAT_VLD] ? wr_entry : '0;

  sw_tbl_rd_seq #(.READ_LAT(READ_LAT)) u_seq (
    .clk_i, .rst_ni, .start_i(rd_go), .busy_o(busy), .done_o(done)
  );

  sw_tbl_small_mem #(.DEPTH(VLAN_DEPTH), .WIDTH(VLAN_W), .CLR_ON_RD(1'b0)) u_vlan (
    .clk_i, .rst_ni,
    .we_i(wr_go && cmd_in.sel == TBL_VLAN), .rd_clr_i(1'b0),
    .idx_i(mem_idx), .wdata_i(wr_entry[VLAN_W-1:0]), .rdata_o(vlan_rdata)
  );

  sw_tbl_small_mem #(.DEPTH(STAT_DEPTH), .WIDTH(STAT_W), .CLR_ON_RD(1'b0)) u_stat (
    .clk_i, .rst_ni,
    .we_i(wr_go && cmd_in.sel == TBL_STATIC), .rd_clr_i(1'b0),
    .idx_i(mem_idx), .wdata_i(stat_wdata), .rdata_o(stat_rdata)
  );

  sw_tbl_small_mem #(.DEPTH(MIB_DEPTH), .WIDTH(32), .CLR_ON_RD(1'b1)) u_mib (
    .clk_i, .rst_ni,
    .we_i(wr_go && cmd_in.sel == TBL_MIB), .rd_clr_i(done && pend_q.sel == TBL_MIB),
    .idx_i(mem_idx), .wdata_i(lo_q), .rdata_o(mib_rdata)
  );

  sw_tbl_dyn_mem #(.DEPTH(DYN_DEPTH), .WIDTH(DYN_W)) u_dyn (
    .clk_i, .rst_ni,
    .we_i(wr_go && cmd_in.sel == TBL_DYN), .idx_i(mem_idx),
    .wdata_i({wr_entry[57:56], wr_entry[54:0]}), .rdata_o(dyn_rdata),
    .in_range_o(dyn_in_range), .empty_o(dyn_empty), .cnt_m1_o(dyn_cnt_m1)
  );

  always_comb begin
    unique case (pend_q.sel)
      TBL_STATIC: rd_entry = ENTRY_W'(stat_rdata);
      TBL_VLAN:   rd_entry = ENTRY_W'(vlan_rdata);
      TBL_DYN:    rd_entry = dyn_in_range
                    ? {dyn_empty, dyn_cnt_m1, dyn_rdata[56:55], 1'b0, dyn_rdata[54:0]}
                    : '0;
      default:    rd_entry = ENTRY_W'(mib_rdata);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      mid_q  <= '0;
      hi_q   <= '0;
      pend_q <= '0;
    end else if (rd_go) begin
      pend_q <= cmd_in;
      lo_q   <= '0;
      mid_q  <= (cmd_in.sel == TBL_DYN) ? NRDY_MASK : '0;
      hi_q   <= '0;
    end else if (done) begin
      {hi_q, mid_q, lo_q} <= rd_entry;
    end else if (accept) begin
      unique case (reg_sel_e'(reg_addr_i))
        REG_LO:  lo_q  <= reg_wdata_i;
        REG_MID: mid_q <= reg_wdata_i;
        REG_HI:  hi_q  <= reg_wdata_i[HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign data_lo_o  = lo_q;
  assign data_mid_o = mid_q;
  assign data_hi_o  = hi_q;
  assign busy_o     = busy;
endmodule

// File: rtl/sw_tbl_access_chk.sv
module sw_tbl_access_chk #(
  parameter int READ_LAT = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [1:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] data_lo_o,
  input logic [31:0] data_mid_o,
  input logic [4:0]  data_hi_o,
  input logic        busy_o
);
  localparam int RW = $clog2(READ_LAT + 2) + 1;

  logic [RW-1:0] run_q;
  logic          dyn_pend_q;
  logic          cmd_seen;

  assign cmd_seen = !busy_o && reg_we_i && (reg_addr_i == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= '0;
      dyn_pend_q <= 1'b0;
    end else begin
      run_q <= busy_o ? run_q + 1'b1 : '0;
      if (cmd_seen && reg_wdata_i[12]) dyn_pend_q <= (reg_wdata_i[11:10] == 2'd2);
    end
  end

  p_rd_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_seen && reg_wdata_i[12] |=> busy_o);

  p_wr_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_seen && !reg_wdata_i[12] |=> !busy_o);

  p_busy_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < RW'(READ_LAT));

  p_busy_exact_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && run_q != '0 |-> run_q == RW'(READ_LAT));

  p_hold_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |->
      $stable(data_lo_o) && $stable(data_mid_o) && $stable(data_hi_o));

  p_nrdy_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && dyn_pend_q |-> data_mid_o[23]);

  p_nrdy_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) && dyn_pend_q |-> !data_mid_o[23]);
endmodule

bind sw_tbl_access sw_tbl_access_chk #(.READ_LAT(READ_LAT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .data_lo_o(data_lo_o), .data_mid_o(data_mid_o),
  .data_hi_o(data_hi_o), .busy_o(busy_o)
);

// File: tb/sw_tbl_access_test.sv
module sw_tbl_access_test;
  localparam int READ_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] data_lo, data_mid;
  logic [4:0]  data_hi;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [68:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  sw_tbl_access #(.READ_LAT(READ_LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .data_lo_o(data_lo), .data_mid_o(data_mid),
    .data_hi_o(data_hi), .busy_o(busy)
  );

  function automatic logic [68:0] cur();
    return {data_hi, data_mid, data_lo};
  endfunction

  task automatic check(string tag, logic [68:0] got, logic [68:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard when a read completes
  bit prev_busy = 1'b0;
  always @(negedge clk) begin
    if (prev_busy && !busy) begin
      if (exp_q.size() == 0) check("R3 unexpected completion", 69'd1, 69'd0);
      else check(tag_q.pop_front(), cur(), exp_q.pop_front());
    end
    prev_busy = busy;
  end

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd(bit rd, logic [1:0] sel, int idx);
    return {19'd0, rd, sel, 10'(idx)};
  endfunction

  task automatic do_write(logic [1:0] sel, int idx, logic [31:0] lo, logic [31:0] mi, logic [4:0] hi);
    wait_idle();
    reg_wr(2'd0, lo);
    reg_wr(2'd1, mi);
    reg_wr(2'd2, {27'd0, hi});
    reg_wr(2'd3, cmd(1'b0, sel, idx));
  endtask

  task automatic do_read(logic [1:0] sel, int idx, logic [68:0] exp, string tag);
    int n;
    wait_idle();
    reg_wr(2'd3, cmd(1'b1, sel, idx));
    check("R4 pending placeholder", cur(), (sel == 2'd2) ? (69'd1 << 55) : 69'd0);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R3 busy length", 69'(n), 69'(READ_LAT));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset data", cur(), 69'd0);
    check("R11 reset busy", 69'(busy), 69'd0);
    rst_n = 1'b1;

    // R2 data register loads
    reg_wr(2'd0, 32'hA5A5_5A5A);
    check("R2 low word", 69'(data_lo), 69'h0A5A5_5A5A);
    reg_wr(2'd1, 32'h1357_9BDF);
    check("R2 middle word", 69'(data_mid), 69'h01357_9BDF);
    reg_wr(2'd2, 32'hFFFF_FFFF);
    check("R2 high word", 69'(data_hi), 69'h1F);

    // R11/R7 empty tables
    do_read(2'd2, 0, {5'h10, 32'h0, 32'h0}, "R7 empty dynamic flag");
    do_read(2'd1, 0, 69'd0, "R11 vlan empty");

    // R5 VLAN
    do_write(2'd1, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'h1F);
    check("R1 write keeps idle", 69'(busy), 69'd0);
    do_read(2'd1, 3, {5'h0, 32'h0, 32'h003F_FFFF}, "R5 vlan entry bits");

    // R9 out of range VLAN
    do_write(2'd1, 20, 32'h0001_2345, 32'h0, 5'h0);
    do_read(2'd1, 20, 69'd0, "R9 vlan out of range read");
    do_read(2'd1, 4, 69'd0, "R9 vlan no alias write");

    // R6 static
    do_write(2'd0, 2, 32'h1122_3344, 32'hFA3F_ABCD, 5'h1F);
    do_read(2'd0, 2, {5'h0, 32'h0A3F_ABCD, 32'h1122_3344}, "R6 static valid entry");
    do_write(2'd0, 5, 32'h0000_0001, 32'h0020_0001, 5'h0);
    do_read(2'd0, 5, {5'h0, 32'h0020_0001, 32'h0000_0001}, "R6 static entry 5");
    do_write(2'd0, 5, 32'h5566_7788, 32'h0A1F_ABCD, 5'h0);
    do_read(2'd0, 5, 69'd0, "R6 static invalidate");
    do_read(2'd0, 9, 69'd0, "R9 static out of range read");
    do_write(2'd0, 10, 32'hFFFF_FFFF, 32'h0FFF_FFFF, 5'h0);
    do_read(2'd0, 2, {5'h0, 32'h0A3F_ABCD, 32'h1122_3344}, "R9 static no alias write");

    // R7 dynamic
    do_write(2'd2, 5, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 5'h1F);
    do_read(2'd2, 5, {5'h0, 32'h037F_FFFF, 32'hDEAD_BEEF}, "R7 dynamic first entry");
    do_write(2'd2, 7, 32'hCAFE_F00D, 32'h0012_3456, 5'h0);
    do_write(2'd2, 5, 32'h0102_0304, 32'h0, 5'h0);
    do_read(2'd2, 7, {5'h0, 32'h0412_3456, 32'hCAFE_F00D}, "R7 dynamic count two");
    do_read(2'd2, 5, {5'h0, 32'h0400_0000, 32'h0102_0304}, "R7 dynamic rewrite");
    do_read(2'd2, 100, {5'h0, 32'h0400_0000, 32'h0}, "R7 dynamic unwritten index");

    // R8 MIB
    do_write(2'd3, 31, 32'h4000_0042, 32'h0, 5'h0);
    do_read(2'd3, 31, {5'h0, 32'h0, 32'h4000_0042}, "R8 mib value");
    do_read(2'd3, 31, 69'd0, "R8 mib cleared on read");
    do_write(2'd3, 40, 32'h0000_0007, 32'h0, 5'h0);
    do_read(2'd3, 40, 69'd0, "R9 mib out of range read");
    do_read(2'd3, 8, 69'd0, "R9 mib no alias write");

    // R10 writes during a pending read are ignored
    wait_idle();
    reg_wr(2'd3, cmd(1'b1, 2'd1, 3));
    exp_q.push_back({5'h0, 32'h0, 32'h003F_FFFF});
    tag_q.push_back("R10 result under writes");
    we = 1'b1; addr = 2'd0; wdata = 32'h0000_0055;
    @(negedge clk);
    addr = 2'd3; wdata = cmd(1'b0, 2'd1, 3);
    @(negedge clk);
    we = 1'b0;
    wait_idle();
    do_read(2'd1, 3, {5'h0, 32'h0, 32'h003F_FFFF}, "R10 table untouched");

    wait_idle();
    repeat (2) @(negedge clk);
    check("R3 all reads completed", 69'(exp_q.size()), 69'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule